// File: doc/BRIEF.md
# IPv4/UDP Lookup Key Extractor

This block sits on the receive side of a line card, between the frame writer and a downstream classifier. Each received Ethernet frame arrives as a stream of 64-bit words on a valid/ready handshake, with the receive port number and the frame length given as sideband on the first word. The block finds where the IP header starts (with or without one 802.1Q tag) and checks the IPv4 header: version, header checksum over the full header length, fragmentation and a sane header length. It then assembles a 64-bit lookup key for the classifier.

The key holds a fixed link-type nibble, the receive port, the IP destination address, the IP protocol byte and the two bytes that a UDP header would carry as its destination port. IP options are never parsed. They are only skipped, using the header length field. As soon as the word carrying the destination-port bytes has been taken, the block holds the result (key, Ethernet header length, frame length, drop flag) on its output port. It stalls the input until the result is accepted. It then consumes and discards the rest of the frame.

Top module: `ipv4_key_extract`

## Requirements
- R1: Byte 0 of a word is in bits [63:56] and byte 7 is in bits [7:0]; word n carries frame bytes 8n..8n+7. The receive port and frame length are sampled with the first word of a frame. A frame ends with the word flagged by `in_last_i`.
- R2: The key is, from MSB to LSB: link type 4'b0101 (4b), receive port (4b), IP destination address (32b, IP header bytes 16..19), IP protocol (8b, IP header byte 9), destination port (16b).
- R3: When frame bytes 12..13 equal 16'h8100, the IP header starts at byte 18 and the reported Ethernet header length is 18. Otherwise the IP header starts at byte 14 and the length is 14.
- R4: The destination port is taken from the two bytes at IP header offset IHL*4+2, where IHL is the low nibble of IP byte 0. Any options before it are skipped. These bytes are used whatever the protocol byte holds.
- R5: A frame whose IP version nibble (high nibble of IP byte 0) is not 4 is flagged as dropped.
- R6: The ones' complement sum of all 16-bit words over IHL*4 header bytes, checksum field included, must be 16'hFFFF. Otherwise the frame is flagged as dropped.
- R7: A frame with the more-fragments flag set (IP byte 6, bit 5) or a nonzero 13-bit fragment offset (IP bytes 6..7, low 13 bits) is flagged as dropped. The don't-fragment flag (IP byte 6, bit 6) alone has no effect on the drop flag.
- R8: A frame with IHL below 5 is flagged as dropped.
- R9: A frame that ends before its destination-port bytes have arrived still produces a result, on its last word, with the drop flag set.
- R10: After reset no result is pending and the input is ready. The result becomes valid the cycle after the word that completes it. While a result is pending, `in_ready_o` is low and the outputs hold steady until accepted. Acceptance clears valid on the next cycle.
- R11: Words of a frame that follow the destination-port word are consumed and ignored. The next frame is parsed from the word after the last one.
- R12: The frame length given with the first word appears unchanged with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 64 | Frame word, byte 0 in the top bits |
| in_last_i | input | 1 | Last word of the frame |
| in_port_i | input | 4 | Receive port, sampled with the first word |
| in_flen_i | input | 16 | Frame length, sampled with the first word |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted when high with valid |
| out_key_o | output | 64 | Lookup key |
| out_ehl_o | output | 8 | Ethernet header length in bytes (14 or 18) |
| out_flen_o | output | 16 | Frame length passed through |
| out_drop_o | output | 1 | Frame fails a header check or is too short |

## Verification
The result capture and the end of the frame can fall on the same input beat. When the destination-port bytes sit in the final word, the block must skip its drain phase and be ready to parse a new frame straight after the hand-off. The sweep provokes this by sending, for every tag and IHL setting, frames with zero trailing words next to frames with one or two extra words. The single-beat case is judged by the next frame's key, header length and drop flag matching their computed values. The same sweep also puts the last checksum lanes and the destination-port lane in one word, for every IHL.

// File: rtl/lkx_pkg.sv
`timescale 1ns/1ps
package lkx_pkg;
  typedef enum logic [1:0] {ST_PARSE, ST_HOLD, ST_DRAIN} lkx_state_e;
  localparam logic [15:0] ETH_VLAN = 16'h8100;
  localparam int ETH_TYPE_OFF = 12;
  localparam int ETH_HL_PLAIN = 14;
  localparam int ETH_HL_TAG   = 18;
endpackage

// File: rtl/lkx_lane.sv
`timescale 1ns/1ps
// Classifies one 16-bit lane by its byte offset relative to the IP header.
module lkx_lane #(
  parameter int OFF_W = 11
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] eh_i,
  input  logic [OFF_W-1:0] hl_i,
  output logic             hdr_o,
  output logic             frag_o,
  output logic             proto_o,
  output logic             dah_o,
  output logic             dal_o,
  output logic             dport_o
);
  logic [OFF_W-1:0] ipoff;
  logic             past;

  assign past  = off_i >= eh_i;
  assign ipoff = off_i - eh_i;

  assign hdr_o   = past && (ipoff < hl_i);
  assign frag_o  = past && (ipoff == OFF_W'(6));
  assign proto_o = past && (ipoff == OFF_W'(8));
  assign dah_o   = past && (ipoff == OFF_W'(16));
  assign dal_o   = past && (ipoff == OFF_W'(18));
  assign dport_o = past && (ipoff == hl_i + OFF_W'(2));
endmodule

// File: rtl/lkx_csum.sv
`timescale 1ns/1ps
// Running ones' complement sum over selected lanes; ok_o reflects the sum including the current word.
module lkx_csum #(
  parameter int LANES = 4,
  parameter int ACC_W = 24,
  localparam int DATA_W = LANES * 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ok_o
);
  logic [ACC_W-1:0] acc_q, sum_c;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  always_comb begin
    sum_c = clr_i ? '0 : acc_q;
    for (int m = 0; m < LANES; m++) begin
      if (lane_en_i[m]) sum_c = sum_c + ACC_W'(data_i[DATA_W-1-16*m -: 16]);
    end
  end

  assign fold1 = {1'b0, sum_c[15:0]} + 17'(sum_c[ACC_W-1:16]);
  assign fold2 = fold1[15:0] + 16'(fold1[16]);
  assign ok_o  = fold2 == 16'hFFFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_c;
  end
endmodule

// File: rtl/ipv4_key_extract.sv
`timescale 1ns/1ps
module ipv4_key_extract import lkx_pkg::*; #(
  parameter int          DATA_W    = 64,
  parameter int          PORT_W    = 4,
  parameter int          LEN_W     = 16,
  parameter int          CNT_W     = 8,
  parameter logic [3:0]  LINK_TYPE = 4'b0101,
  localparam int         KEY_W     = 4 + PORT_W + 32 + 8 + 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [PORT_W-1:0] in_port_i,
  input  logic [LEN_W-1:0]  in_flen_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [KEY_W-1:0]  out_key_o,
  output logic [7:0]        out_ehl_o,
  output logic [LEN_W-1:0]  out_flen_o,
  output logic              out_drop_o
);
  localparam int LANES = DATA_W / 16;
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);
  localparam int OFF_W = CNT_W + SH;

  lkx_state_e         state_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic [OFF_W-1:0]   eh_q;
  logic [3:0]         ihl_q, ver_q;
  logic               frag_q;
  logic [7:0]         proto_q;
  logic [31:0]        da_q;
  logic [PORT_W-1:0]  port_q;
  logic [LEN_W-1:0]   flen_q;
  logic               last_q;

  logic [KEY_W-1:0]   key_q;
  logic [7:0]         ehl_q;
  logic [LEN_W-1:0]   oflen_q;
  logic               drop_q;

  logic               beat, parse_beat, capture, first;
  logic [OFF_W-1:0]   wbase;
  logic [OFF_W-1:0]   lane_off [LANES];
  logic [15:0]        lane_hw  [LANES];

  logic [OFF_W-1:0]   eh_cur, hl_cur;
  logic [3:0]         ihl_cur, ver_cur;
  logic               ihl_bad;
  logic               frag_cur;
  logic [7:0]         proto_cur;
  logic [31:0]        da_cur;
  logic [15:0]        dport_cur;
  logic               dport_seen;
  logic [PORT_W-1:0]  port_cur;
  logic [LEN_W-1:0]   flen_cur;
  logic               csum_ok;

  logic [LANES-1:0]   hdr_hit, frag_hit, proto_hit, dah_hit, dal_hit, dport_hit;

  assign in_ready_o  = state_q != ST_HOLD;
  assign out_valid_o = state_q == ST_HOLD;
  assign beat        = in_valid_i && in_ready_o;
  assign parse_beat  = beat && (state_q == ST_PARSE);
  assign first       = wcnt_q == '0;
  assign wbase       = OFF_W'(wcnt_q) << SH;

  for (genvar m = 0; m < LANES; m++) begin : g_lane
    assign lane_off[m] = wbase + OFF_W'(2 * m);
    assign lane_hw[m]  = in_data_i[DATA_W-1-16*m -: 16];

    lkx_lane #(.OFF_W(OFF_W)) u_lane (
      .off_i   (lane_off[m]),
      .eh_i    (eh_cur),
      .hl_i    (hl_cur),
      .hdr_o   (hdr_hit[m]),
      .frag_o  (frag_hit[m]),
      .proto_o (proto_hit[m]),
      .dah_o   (dah_hit[m]),
      .dal_o   (dal_hit[m]),
      .dport_o (dport_hit[m])
    );
  end

  // Tag detection: lane holding the outer EtherType decides where IP begins.
  always_comb begin
    eh_cur = first ? OFF_W'(ETH_HL_PLAIN) : eh_q;
    for (int m = 0; m < LANES; m++) begin
      if (lane_off[m] == OFF_W'(ETH_TYPE_OFF))
        eh_cur = (lane_hw[m] == ETH_VLAN) ? OFF_W'(ETH_HL_TAG) : OFF_W'(ETH_HL_PLAIN);
    end
  end

  // Version / IHL may arrive in the same word as later header lanes.
  always_comb begin
    ihl_cur = first ? 4'd5 : ihl_q;
    ver_cur = first ? 4'd0 : ver_q;
    for (int m = 0; m < LANES; m++) begin
      if (lane_off[m] == eh_cur) begin
        ver_cur = lane_hw[m][15:12];
        ihl_cur = lane_hw[m][11:8];
      end
    end
    ihl_bad = ihl_cur < 4'd5;
    hl_cur  = ihl_bad ? OFF_W'(20) : OFF_W'({ihl_cur, 2'b00});
  end

  always_comb begin
    frag_cur   = first ? 1'b0  : frag_q;
    proto_cur  = first ? 8'h00 : proto_q;
    da_cur     = first ? '0    : da_q;
    dport_cur  = '0;
    dport_seen = 1'b0;
    for (int m = 0; m < LANES; m++) begin
      if (frag_hit[m])  frag_cur = frag_cur | lane_hw[m][13] | (|lane_hw[m][12:0]);
      if (proto_hit[m]) proto_cur = lane_hw[m][7:0];
      if (dah_hit[m])   da_cur[31:16] = lane_hw[m];
      if (dal_hit[m])   da_cur[15:0] = lane_hw[m];
      if (dport_hit[m]) begin
        dport_cur  = lane_hw[m];
        dport_seen = 1'b1;
      end
    end
  end

  assign port_cur = first ? in_port_i : port_q;
  assign flen_cur = first ? in_flen_i : flen_q;
  assign capture  = parse_beat && (dport_seen || in_last_i);

  lkx_csum #(.LANES(LANES)) u_csum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (parse_beat),
    .clr_i     (first),
    .lane_en_i (hdr_hit),
    .data_i    (in_data_i),
    .ok_o      (csum_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PARSE;
      wcnt_q  <= '0;
      eh_q    <= OFF_W'(ETH_HL_PLAIN);
      ihl_q   <= 4'd5;
      ver_q   <= 4'd0;
      frag_q  <= 1'b0;
      proto_q <= '0;
      da_q    <= '0;
      port_q  <= '0;
      flen_q  <= '0;
      last_q  <= 1'b0;
      key_q   <= '0;
      ehl_q   <= '0;
      oflen_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_PARSE: begin
          if (parse_beat) begin
            eh_q    <= eh_cur;
            ihl_q   <= ihl_cur;
            ver_q   <= ver_cur;
            frag_q  <= frag_cur;
            proto_q <= proto_cur;
            da_q    <= da_cur;
            port_q  <= port_cur;
            flen_q  <= flen_cur;
            if (wcnt_q != '1) wcnt_q <= wcnt_q + 1'b1;
            if (capture) begin
              key_q   <= {LINK_TYPE, port_cur, da_cur, proto_cur, dport_cur};
              ehl_q   <= 8'(eh_cur);
              oflen_q <= flen_cur;
              drop_q  <= !dport_seen || (ver_cur != 4'd4) || frag_cur || !csum_ok || ihl_bad;
              last_q  <= in_last_i;
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (out_ready_i) begin
            wcnt_q  <= '0;
            state_q <= last_q ? ST_PARSE : ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (beat && in_last_i) state_q <= ST_PARSE;
        end
        default: state_q <= ST_PARSE;
      endcase
    end
  end

  assign out_key_o  = key_q;
  assign out_ehl_o  = ehl_q;
  assign out_flen_o = oflen_q;
  assign out_drop_o = drop_q;
endmodule

// File: rtl/lkx_chk.sv
`timescale 1ns/1ps
module lkx_chk #(
  parameter int         KEY_W     = 64,
  parameter int         LEN_W     = 16,
  parameter logic [3:0] LINK_TYPE = 4'b0101
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [KEY_W-1:0] out_key_o,
  input logic [7:0]       out_ehl_o,
  input logic [LEN_W-1:0] out_flen_o,
  input logic             out_drop_o
);
  // R10
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_key_o) && $stable(out_drop_o)
      && $stable(out_flen_o) && $stable(out_ehl_o));

  // R10
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o);

  // R2
  link_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_key_o[KEY_W-1 -: 4] == LINK_TYPE);

  // R3
  ehl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_drop_o |-> (out_ehl_o == 8'd14) || (out_ehl_o == 8'd18));
endmodule

bind ipv4_key_extract lkx_chk #(.KEY_W(KEY_W), .LEN_W(LEN_W), .LINK_TYPE(LINK_TYPE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_key_o   (out_key_o),
  .out_ehl_o   (out_ehl_o),
  .out_flen_o  (out_flen_o),
  .out_drop_o  (out_drop_o)
);

// File: tb/ipv4_key_extract_tb.sv
`timescale 1ns/1ps
module ipv4_key_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [3:0]  in_port = '0;
  logic [15:0] in_flen = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_key;
  logic [7:0]  out_ehl;
  logic [15:0] out_flen;
  logic        out_drop;

  always #2.5 clk = ~clk;

  ipv4_key_extract u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_last_i(in_last), .in_port_i(in_port), .in_flen_i(in_flen),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_key_o(out_key),
    .out_ehl_o(out_ehl), .out_flen_o(out_flen), .out_drop_o(out_drop)
  );

  logic [7:0]  fb [0:255];
  int          nw;
  int          n_chk = 0, n_bad = 0, n_sent = 0, n_recv = 0, cyc = 0;
  logic [63:0] e_key  [0:511];
  logic        e_drop [0:511];
  logic [7:0]  e_ehl  [0:511];
  logic [15:0] e_flen [0:511];
  logic        e_short[0:511];
  string       e_tag  [0:511];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Builds frame bytes and records the expected result computed from the requirements.
  task automatic build(input int tag, input int ihl, input int ver, input int mf, input int df,
                       input int foff, input int badck, input int proto, input int trunc,
                       input int extra, input string rq);
    int e, hl, need;
    logic [31:0] sum;
    logic [15:0] ck;
    e  = tag ? 18 : 14;
    hl = (ihl < 5) ? 20 : ihl * 4;
    for (int i = 0; i < 256; i++) fb[i] = 8'((i * 29 + n_sent * 11 + 5) & 255);
    if (tag != 0) begin
      fb[12] = 8'h81; fb[13] = 8'h00; fb[16] = 8'h08; fb[17] = 8'h00;
    end else begin
      fb[12] = 8'h08; fb[13] = 8'h00;
    end
    fb[e]    = {4'(ver), 4'(ihl)};
    fb[e+6]  = {1'b0, 1'(df), 1'(mf), 5'(foff >> 8)};
    fb[e+7]  = 8'(foff);
    fb[e+9]  = 8'(proto);
    fb[e+10] = 8'h00;
    fb[e+11] = 8'h00;
    sum = 0;
    for (int i = 0; i < hl; i += 2) sum = sum + {16'h0, fb[e+i], fb[e+i+1]};
    sum = {16'h0, sum[15:0]} + {16'h0, sum[31:16]};
    sum = {16'h0, sum[15:0]} + {16'h0, sum[31:16]};
    ck = ~sum[15:0];
    if (badck != 0) ck = ck ^ 16'h0001;
    fb[e+10] = ck[15:8];
    fb[e+11] = ck[7:0];
    need = (e + hl + 4 + 7) / 8;
    nw   = (trunc != 0) ? need - 1 : need + extra;
    // R1 R2: key layout from the byte positions
    e_key[n_sent]   = {4'b0101, 4'(n_sent), fb[e+16], fb[e+17], fb[e+18], fb[e+19],
                       fb[e+9], fb[e+hl+2], fb[e+hl+3]};
    e_drop[n_sent]  = (trunc != 0) || (ver != 4) || (badck != 0) || (mf != 0) || (foff != 0) || (ihl < 5);
    e_ehl[n_sent]   = 8'(e);
    e_flen[n_sent]  = 16'(n_sent * 37 + 64);
    e_short[n_sent] = trunc != 0;
    e_tag[n_sent]   = rq;
  endtask

  task automatic send_word(input logic [63:0] w, input logic l, input int idx);
    bit rdy;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    in_last  = l;
    in_port  = 4'(idx);
    in_flen  = 16'(idx * 37 + 64);
    while (1) begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame();
    logic [63:0] w;
    int idx;
    idx = n_sent;
    n_sent++;
    for (int k = 0; k < nw; k++) begin
      for (int j = 0; j < 8; j++) w[63-8*j -: 8] = fb[8*k+j];
      send_word(w, k == nw - 1, idx);
      if (((k + idx) % 5) == 0) idle();
    end
  endtask

  // Result monitor: ready pattern set at the falling edge, result judged when handed over.
  always @(negedge clk) begin
    cyc++;
    out_ready = (cyc % 4) != 1;
    if (rst_n && out_valid) begin
      chk(!in_ready, "R10", "input stall while pending", {63'h0, in_ready}, 64'h0);
      if (out_ready) begin
        chk(out_drop == e_drop[n_recv], e_tag[n_recv], "drop", {63'h0, out_drop}, {63'h0, e_drop[n_recv]});
        chk(out_flen == e_flen[n_recv], "R12", "frame length", {48'h0, out_flen}, {48'h0, e_flen[n_recv]});
        if (!e_short[n_recv]) begin
          // R11: previous frame's trailing words must not disturb this key
          chk(out_key == e_key[n_recv], "R1 R2 R4 R11", "key", out_key, e_key[n_recv]);
          chk(out_ehl == e_ehl[n_recv], "R3", "eth header length", {56'h0, out_ehl}, {56'h0, e_ehl[n_recv]});
        end
        n_recv++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual %0d results expected %0d", n_recv, n_sent);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "reset valid", {63'h0, out_valid}, 64'h0);
    chk(in_ready == 1'b1, "R10", "reset ready", {63'h0, in_ready}, 64'h1);

    for (int tag = 0; tag < 2; tag++) begin
      for (int ihl = 5; ihl < 16; ihl++) begin
        for (int c = 0; c < 7; c++) begin
          case (c)
            0: build(tag, ihl, 4, 0, 0, 0,     0, 17, 0, (ihl + c) % 3, "R6");
            1: build(tag, ihl, 4, 0, 0, 0,     0, 6,  0, (ihl + c) % 3, "R4");
            2: build(tag, ihl, 6, 0, 0, 0,     0, 17, 0, (ihl + c) % 3, "R5");
            3: build(tag, ihl, 4, 0, 0, 0,     1, 17, 0, (ihl + c) % 3, "R6");
            4: build(tag, ihl, 4, 1, 0, 0,     0, 17, 0, (ihl + c) % 3, "R7");
            5: build(tag, ihl, 4, 0, 0, 'h155, 0, 17, 0, (ihl + c) % 3, "R7");
            default: build(tag, ihl, 4, 0, 1, 0, 0, 17, 0, (ihl + c) % 3, "R7");
          endcase
          send_frame();
        end
      end
    end

    // R8: header length below minimum
    for (int ihl = 0; ihl < 5; ihl++) begin
      build(ihl % 2, ihl, 4, 0, 0, 0, 0, 17, 0, 1, "R8");
      send_frame();
    end

    // R9: frames ending before the destination-port bytes
    for (int tag = 0; tag < 2; tag++) begin
      for (int s = 0; s < 3; s++) begin
        build(tag, 5 + 5 * s, 4, 0, 0, 0, 0, 17, 1, 0, "R9");
        send_frame();
        build(tag, 5 + 5 * s, 4, 0, 0, 0, 0, 17, 0, 0, "R6");
        send_frame();
      end
    end

    idle();
    while (n_recv < n_sent) @(posedge clk);
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule